// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block decides, for each of several clock outputs, whether that output runs or is held low. It then gates the outputs so that a start or a stop never produces a short pulse. Two active-low stop requests drive the decision: one governs the processor-side groups and one governs the peripheral-bus group. A strap input can turn both requests off. Each output also has its own enable bit from a control register. A power-up settle flag must be seen before any output starts.

Every clock the block sees is sampled in one fast system clock domain. This covers the free-running reference clock and the source clock behind each output. A change between running and stopped is not applied at once. The lane first waits for a rising edge of the reference clock, and then for the next falling edge of its own source clock. Only then does it open or close the gate. Outputs therefore always stop low and keep full high pulses. The reference clock is passed through to its own output and is never gated.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Once a lane has settled in the stopped state, its gated output stays at logic 0.
- R2: Every high pulse of a gated output lasts exactly as many system cycles as the high phase of its source clock, including the last pulse before a stop and the first pulse after a start.
- R3: A lane leaves its running or stopped state only after a reference-clock rising edge has been seen, followed by a falling edge of its own source clock. A stop request placed just after a reference rising edge lets at least one further full pulse out.
- R4: Each lane's group comes from parameter GROUP_MAP, 2 bits per lane: 0 = free, 1 = processor group, 2 = bus group. With mode_i = 0, a low cpu_stop_ni stops the processor-group lanes and a low pci_stop_ni stops the bus-group lanes. Free lanes run under every combination of the stop inputs.
- R5: With mode_i = 1 both stop inputs are ignored: every enabled lane runs whatever levels cpu_stop_ni and pci_stop_ni have.
- R6: A lane runs only if its bit in en_i is 1 and its stop input allows it. Clearing the en_i bit stops that lane even while its stop input is high.
- R7: After reset every output is low, and it stays low until settle_done_i is 1.
- R8: ref_clk_o follows the reference clock under every stop and enable setting.
- R9: A request that changes while a lane is in mid-sequence is evaluated again once that sequence has completed. The lane ends in the state that the final request level asks for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock used to sample every clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Free-running reference clock |
| src_clk_i | input | N_OUT | Source clock for each lane |
| cpu_stop_ni | input | 1 | Active-low stop request, processor group |
| pci_stop_ni | input | 1 | Active-low stop request, bus group |
| mode_i | input | 1 | 1 = ignore both stop requests |
| en_i | input | N_OUT | Per-lane enable from the control register |
| settle_done_i | input | 1 | Power-up settle finished |
| ref_clk_o | output | 1 | Ungated reference clock, resampled |
| gclk_o | output | N_OUT | Gated clock per lane |

## Verification
The hardest case to reach is a stop that arrives just after a reference rising edge. Here the sequencer misses that edge and must wait almost a whole reference period. A design that skipped the reference wait would stop earlier. The bench derives the reference clock and every source clock from one cycle counter. It therefore knows their phases, and it issues the stop on the cycle after it raises the reference clock. It then counts the further full pulses the lane lets out. A pulse monitor runs during every scenario and compares each output high time with its source high time, so a clipped last or first pulse is caught wherever it happens.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WREF  = 2'd1,
    ST_WFALL = 2'd2,
    ST_STOP  = 2'd3
  } lane_st_e;

  localparam logic [1:0] GRP_FREE = 2'd0;
  localparam logic [1:0] GRP_CPU  = 2'd1;
  localparam logic [1:0] GRP_PCI  = 2'd2;
endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/clk_stop_lane.sv
module clk_stop_lane
  import clk_stop_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     want_i,
  input  logic     ref_rise_i,
  input  logic     src_s_i,
  input  logic     src_fall_i,
  output logic     run_o,
  output lane_st_e st_o,
  output logic     gclk_o
);
  lane_st_e st_q, st_d;
  logic     tgt_q, tgt_d;
  logic     run_q, run_d;
  logic     gclk_q;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    run_d = run_q;
    unique case (st_q)
      ST_RUN:   if (!want_i) begin st_d = ST_WREF; tgt_d = 1'b0; end
      ST_STOP:  if (want_i)  begin st_d = ST_WREF; tgt_d = 1'b1; end
      ST_WREF:  if (ref_rise_i) st_d = ST_WFALL;
      ST_WFALL: if (src_fall_i) begin
        // source is low here, so the gate flips between pulses
        run_d = tgt_q;
        st_d  = tgt_q ? ST_RUN : ST_STOP;
      end
      default:  st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_STOP;
      tgt_q  <= 1'b0;
      run_q  <= 1'b0;
      gclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      run_q  <= run_d;
      gclk_q <= src_s_i & run_q;
    end
  end

  assign run_o  = run_q;
  assign st_o   = st_q;
  assign gclk_o = gclk_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int               N_OUT     = 4,
  parameter logic [2*N_OUT-1:0] GROUP_MAP = {GRP_CPU, GRP_FREE, GRP_PCI, GRP_CPU}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic [N_OUT-1:0] src_clk_i,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             mode_i,
  input  logic [N_OUT-1:0] en_i,
  input  logic             settle_done_i,
  output logic             ref_clk_o,
  output logic [N_OUT-1:0] gclk_o
);
  localparam int SW = N_OUT + 3;

  logic [SW-1:0]    raw, syn;
  logic [N_OUT-1:0] src_s, src_q, src_fall, want, lane_run;
  logic             ref_s, ref_q, ref_rise, cpu_ok, pci_ok;
  lane_st_e         lane_st [N_OUT];

  assign raw = {src_clk_i, ref_clk_i, cpu_stop_ni, pci_stop_ni};

  clk_stop_sync #(.W(SW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign src_s = syn[SW-1:3];
  assign ref_s = syn[2];
  // mode strap disables the stop function
  assign cpu_ok = mode_i | syn[1];
  assign pci_ok = mode_i | syn[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      ref_q <= 1'b0;
    end else begin
      src_q <= src_s;
      ref_q <= ref_s;
    end
  end

  assign ref_rise  = ref_s & ~ref_q;
  assign src_fall  = ~src_s & src_q;
  assign ref_clk_o = ref_q;

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    localparam logic [1:0] GRP = GROUP_MAP[2*i +: 2];
    logic pin_ok;
    if (GRP == GRP_CPU) begin : g_cpu
      assign pin_ok = cpu_ok;
    end else if (GRP == GRP_PCI) begin : g_pci
      assign pin_ok = pci_ok;
    end else begin : g_free
      assign pin_ok = 1'b1;
    end
    assign want[i] = settle_done_i & en_i[i] & pin_ok;

    clk_stop_lane u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .want_i    (want[i]),
      .ref_rise_i(ref_rise),
      .src_s_i   (src_s[i]),
      .src_fall_i(src_fall[i]),
      .run_o     (lane_run[i]),
      .st_o      (lane_st[i]),
      .gclk_o    (gclk_o[i])
    );
  end
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk
  import clk_stop_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_rise,
  input logic [N_OUT-1:0] src_s,
  input logic [N_OUT-1:0] src_fall,
  input logic [N_OUT-1:0] lane_run,
  input logic [N_OUT-1:0] gclk_o,
  input lane_st_e         lane_st [N_OUT]
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    // R1: settled-stopped lane drives low
    a_r1_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_st[i] == ST_STOP && $past(lane_st[i]) == ST_STOP) |-> !gclk_o[i]);

    // R2: gate only flips right after a source falling edge
    a_r2_gate_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_run[i] != $past(lane_run[i])) |-> $past(src_fall[i]));

    // R2: output high only while source sampled high
    a_r2_high_follows_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gclk_o[i] |-> $past(src_s[i]));

    // R3: leaving the reference wait needs a reference rising edge
    a_r3_ref_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(lane_st[i]) == ST_WREF && lane_st[i] != ST_WREF) |-> $past(ref_rise));

    // R3: settling into run/stop comes only out of the fall wait
    a_r3_settle_from_wfall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((lane_st[i] == ST_RUN || lane_st[i] == ST_STOP) && $past(lane_st[i]) != lane_st[i])
        |-> $past(lane_st[i]) == ST_WFALL);
  end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ref_rise(ref_rise),
  .src_s   (src_s),
  .src_fall(src_fall),
  .lane_run(lane_run),
  .gclk_o  (gclk_o),
  .lane_st (lane_st)
);

// File: tb/tb_clk_stop_ctrl.sv
module tb_clk_stop_ctrl;
  localparam int N = 4;
  localparam int REF_P = 12;
  localparam int PER [N] = '{8, 6, 10, 14};
  localparam int HI  [N] = '{4, 3, 5, 7};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_clk = 1'b0;
  logic [N-1:0] src = '0, en = '0, gclk;
  logic cpu_n = 1'b1, pci_n = 1'b1, mode = 1'b0, settle = 1'b0, ref_o;

  int checks = 0, errors = 0;
  int rises [N], hcnt [N], plen [N], perr [N];
  int ref_rises = 0;
  logic [N-1:0] gprev = '0;
  logic ref_oprev = 1'b0;

  always #4 clk = ~clk;

  clk_stop_ctrl #(.N_OUT(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk), .src_clk_i(src),
    .cpu_stop_ni(cpu_n), .pci_stop_ni(pci_n), .mode_i(mode), .en_i(en),
    .settle_done_i(settle), .ref_clk_o(ref_o), .gclk_o(gclk)
  );

  // clock sources from one counter, driven at negedge
  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      ref_clk = (cyc % REF_P) < REF_P / 2;
      for (int i = 0; i < N; i++) src[i] = (cyc % PER[i]) < HI[i];
    end
  end

  // pulse monitor
  initial begin
    for (int i = 0; i < N; i++) begin rises[i] = 0; hcnt[i] = 0; plen[i] = 0; perr[i] = 0; end
    forever begin
      @(negedge clk);
      if (ref_o && !ref_oprev) ref_rises++;
      ref_oprev = ref_o;
      for (int i = 0; i < N; i++) begin
        if (gclk[i]) begin
          hcnt[i]++;
          plen[i]++;
          if (!gprev[i]) rises[i]++;
        end else if (gprev[i]) begin
          if (plen[i] != HI[i]) perr[i]++;
          plen[i] = 0;
        end
      end
      gprev = gclk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // settle, then return per-lane rise count over a window
  task automatic window(input int settle_cyc, input int len, output int r [N]);
    int base [N];
    repeat (settle_cyc) @(negedge clk);
    for (int i = 0; i < N; i++) base[i] = rises[i];
    repeat (len) @(negedge clk);
    for (int i = 0; i < N; i++) r[i] = rises[i] - base[i];
  endtask

  task automatic expect_run(input string req, input logic [N-1:0] exp_run);
    int r [N];
    window(80, 60, r);
    for (int i = 0; i < N; i++) check(req, int'(r[i] > 0), int'(exp_run[i]));
  endtask

  task automatic t_reset;
    int h0;
    check("R7 reset", int'(gclk), 0);
    rst_ni = 1'b1;
    en = '1;
    h0 = hcnt[0] + hcnt[1] + hcnt[2] + hcnt[3];
    repeat (100) @(negedge clk);
    check("R7 before settle", hcnt[0] + hcnt[1] + hcnt[2] + hcnt[3] - h0, 0);
  endtask

  task automatic t_all_run;
    settle = 1'b1;
    expect_run("R4 all run", 4'b1111);
  endtask

  task automatic t_cpu_stop;
    int h;
    cpu_n = 1'b0;
    expect_run("R4 cpu stop", 4'b0110);
    h = hcnt[0];
    repeat (30) @(negedge clk);
    check("R1 held low", hcnt[0] - h, 0);
  endtask

  task automatic t_both_stop;
    int rr;
    pci_n = 1'b0;
    rr = ref_rises;
    expect_run("R4 both stop", 4'b0100);
    check("R8 ref runs", int'(ref_rises - rr > 5), 1);
  endtask

  task automatic t_mode;
    mode = 1'b1;
    expect_run("R5 mode ignores stops", 4'b1111);
    mode = 1'b0;
    cpu_n = 1'b1;
    pci_n = 1'b1;
    expect_run("R4 release", 4'b1111);
  endtask

  task automatic t_enable;
    en = 4'b1101;
    expect_run("R6 enable cleared", 4'b1101);
    en = '1;
    expect_run("R6 enable set", 4'b1111);
  endtask

  task automatic t_order;
    int b;
    // wait for a reference rising edge, request a stop one cycle later
    @(negedge clk);
    while (!ref_clk) @(negedge clk);
    @(negedge clk);
    b = rises[0];
    cpu_n = 1'b0;
    repeat (40) @(negedge clk);
    check("R3 pulse after late request", int'(rises[0] - b >= 1), 1);
    repeat (40) @(negedge clk);
    check("R3 stopped", int'(gclk[0]), 0);
    cpu_n = 1'b1;
    expect_run("R3 restart", 4'b1111);
  endtask

  task automatic t_midseq;
    // glitch the request: stop then release while sequencing
    cpu_n = 1'b0;
    repeat (6) @(negedge clk);
    cpu_n = 1'b1;
    expect_run("R9 ends running", 4'b1111);
    cpu_n = 1'b0;
    repeat (4) @(negedge clk);
    cpu_n = 1'b1;
    repeat (4) @(negedge clk);
    cpu_n = 1'b0;
    expect_run("R9 ends stopped", 4'b0110);
    cpu_n = 1'b1;
  endtask

  task automatic t_pulses;
    repeat (60) @(negedge clk);
    for (int i = 0; i < N; i++) check("R2 pulse width", perr[i], 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_all_run();
    t_cpu_stop();
    t_both_stop();
    t_mode();
    t_enable();
    t_order();
    t_midseq();
    t_pulses();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule